// File: doc/BRIEF.md
# Biased Pseudo-Random Input Vector Sequencer

This block supplies the primary-input vectors for on-chip functional two-pattern delay testing of a sequential circuit. A single shift register of `NUM_IN*SLICE_W` bits is cut into `NUM_IN` disjoint slices of `SLICE_W` bits, one slice per primary input. A two-bit preference code per input then skews that input's value:

- A preferred 0 takes the AND of the low `COMB_W` bits of its slice.
- A preferred 1 takes the OR of those bits.
- A don't-care input passes the lowest slice bit through unchanged.

Skewing the values this way keeps the same state variables from being forced to the same value over and over.

A sequencer walks a table of seeds in order. For each seed it loads the register and raises a one-cycle request that the circuit under test be put into its functional initial state. It then emits exactly `SEQ_LEN` vectors, one per cycle, under a valid strobe. After the last seed it raises a sticky completion flag. All seeds share the same length, slice width and combine width, so one set of generating logic serves every test.

Top module: `biasVecGen`

## Requirements
- R1: After reset `vecValid`, `initReq`, `seqDone` and `allDone` are all low, and they stay low until `start` is raised.
- R2: When `start` is sampled high while idle or finished, `initReq` is high for exactly the following cycle. `vecValid` is then high for exactly `SEQ_LEN` consecutive cycles, and `initReq`, `vecValid` and `allDone` are never high together.
- R3: `seqDone` is a one-cycle pulse that is high in the same cycle as the `SEQ_LEN`-th valid vector of each seed.
- R4: The register advances as `next = {s[W-2:0], ^(s & TAP_MASK)}`, where W = NUM_IN*SLICE_W and the default `TAP_MASK` is 16'hB400. The k-th vector of a seed (k from 0) is derived from the loaded seed advanced k times.
- R5: A seed of all zeros is loaded as `ZERO_SEED` (default 16'hACE1) instead.
- R6: Input i occupies register bits [i*SLICE_W +: SLICE_W] and owns cube bits [2i+1:2i]. With code 2'b00, `vecOut[i]` is the AND of slice bits [COMB_W-1:0].
- R7: With cube code 2'b01, `vecOut[i]` is the OR of slice bits [COMB_W-1:0].
- R8: With cube code 2'b10 or 2'b11, `vecOut[i]` equals slice bit 0.
- R9: Seed j is taken from `seedTable[j*W +: W]`, and seeds are applied in order j = 0, 1, 2, and so on. The `initReq` of the next seed comes in the cycle right after `seqDone`.
- R10: After the last seed's `seqDone`, `allDone` is high from the next cycle and stays high until `start`. A `start` raised while a seed is running has no effect.
- R11: `start` given while `allDone` is high restarts the walk from seed 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk over the seed table |
| seedTable | input | NUM_SEEDS*NUM_IN*SLICE_W | Packed seeds, seed j at [j*W +: W] |
| cubeCfg | input | 2*NUM_IN | Preference code per input |
| vecOut | output | NUM_IN | Biased primary-input vector |
| vecValid | output | 1 | vecOut carries a test vector |
| initReq | output | 1 | Force the circuit to its initial state |
| seqDone | output | 1 | Last vector of the current seed |
| allDone | output | 1 | All seeds applied |

## Verification
The assertions watch the framing on every cycle:
- `initReq` is always followed by valid data.
- Valid data runs on until `seqDone`.
- `seqDone` lasts one cycle and is followed by either a new `initReq` or `allDone`.
- `allDone` holds until `start`.
- A loaded register is never zero.

Only the bench's scenarios can show the rest. That covers the exact vector values under each preference code, the register sequence, the substitution of a zero seed, the order of the seed table, that a mid-run `start` is ignored, and the restart from seed 0.

// File: rtl/biasvec_pkg.sv
package biasvec_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } seqState_t;

  typedef struct packed {
    logic load;
    logic step;
  } ctlStrobe_t;

  localparam logic [1:0] CUBE_AND = 2'b00;
  localparam logic [1:0] CUBE_OR  = 2'b01;

endpackage

// File: rtl/biasvec_bias.sv
module biasvec_bias #(
  parameter int NUM_IN = 4,
  parameter int COMB_W = 3
) (
  input  logic [NUM_IN*COMB_W-1:0] usedBits,
  input  logic [2*NUM_IN-1:0]      cubeCfg,
  output logic [NUM_IN-1:0]        vecBits
);
  import biasvec_pkg::*;

  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_in
    logic [COMB_W-1:0] grp;
    logic [1:0]        code;
    assign grp  = usedBits[gi*COMB_W +: COMB_W];
    assign code = cubeCfg[2*gi +: 2];
    always_comb begin
      case (code)
        CUBE_AND: vecBits[gi] = &grp;
        CUBE_OR:  vecBits[gi] = |grp;
        default:  vecBits[gi] = grp[0];
      endcase
    end
  end

endmodule

// File: rtl/biasvec_dp.sv
module biasvec_dp #(
  parameter int NUM_IN    = 4,
  parameter int SLICE_W   = 4,
  parameter int COMB_W    = 3,
  parameter int NUM_SEEDS = 3,
  parameter logic [NUM_IN*SLICE_W-1:0] TAP_MASK  = 16'hB400,
  parameter logic [NUM_IN*SLICE_W-1:0] ZERO_SEED = 16'hACE1,
  localparam int LFSR_W = NUM_IN * SLICE_W,
  localparam int SEL_W  = (NUM_SEEDS > 1) ? $clog2(NUM_SEEDS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  biasvec_pkg::ctlStrobe_t     strb,
  input  logic [SEL_W-1:0]            seedSel,
  input  logic [NUM_SEEDS*LFSR_W-1:0] seedTable,
  input  logic [2*NUM_IN-1:0]         cubeCfg,
  output logic [NUM_IN-1:0]           vecBits
);

  logic [LFSR_W-1:0]        lfsr;
  logic [LFSR_W-1:0]        rawSeed;
  logic [LFSR_W-1:0]        fixSeed;
  logic                     feedback;
  logic [NUM_IN*COMB_W-1:0] usedBits;

  assign rawSeed  = seedTable[int'(seedSel)*LFSR_W +: LFSR_W];
  assign fixSeed  = (rawSeed == '0) ? ZERO_SEED : rawSeed;
  assign feedback = ^(lfsr & TAP_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n)          lfsr <= ZERO_SEED;
    else if (strb.load)  lfsr <= fixSeed;
    else if (strb.step)  lfsr <= {lfsr[LFSR_W-2:0], feedback};
  end

  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_pick
    assign usedBits[gi*COMB_W +: COMB_W] = lfsr[gi*SLICE_W +: COMB_W];
  end

  biasvec_bias #(.NUM_IN(NUM_IN), .COMB_W(COMB_W)) i_bias (
    .usedBits(usedBits),
    .cubeCfg (cubeCfg),
    .vecBits (vecBits)
  );

  assert_seed_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load |=> (lfsr != '0));

endmodule

// File: rtl/biasvec_ctl.sv
module biasvec_ctl #(
  parameter int SEQ_LEN   = 8,
  parameter int NUM_SEEDS = 3,
  localparam int CNT_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1,
  localparam int SEL_W = (NUM_SEEDS > 1) ? $clog2(NUM_SEEDS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  output biasvec_pkg::ctlStrobe_t strb,
  output logic [SEL_W-1:0]        seedSel,
  output logic                    initReq,
  output logic                    vecValid,
  output logic                    seqDone,
  output logic                    allDone
);
  import biasvec_pkg::*;

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [SEL_W-1:0] seedIdx;
  logic             lastVec;
  logic             lastSeed;

  assign lastVec  = (cnt == CNT_W'(SEQ_LEN - 1));
  assign lastSeed = (seedIdx == SEL_W'(NUM_SEEDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      seedIdx <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            state   <= ST_LOAD;
            seedIdx <= '0;
            cnt     <= '0;
          end
        end
        ST_LOAD: begin
          state <= ST_RUN;
          cnt   <= '0;
        end
        ST_RUN: begin
          if (lastVec) begin
            cnt <= '0;
            if (lastSeed) begin
              state <= ST_DONE;
            end else begin
              state   <= ST_LOAD;
              seedIdx <= seedIdx + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load = (state == ST_LOAD);
    strb.step = (state == ST_RUN);
  end

  assign seedSel  = seedIdx;
  assign initReq  = (state == ST_LOAD);
  assign vecValid = (state == ST_RUN);
  assign seqDone  = (state == ST_RUN) && lastVec;
  assign allDone  = (state == ST_DONE);

  assert_init_then_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    initReq |=> vecValid);
  assert_valid_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (vecValid && !seqDone) |=> vecValid);
  assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({initReq, vecValid, allDone}));
  assert_done_in_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seqDone |-> vecValid);
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seqDone |=> !seqDone);
  assert_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seqDone |=> (initReq || allDone));
  assert_all_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (allDone && !start) |=> allDone);

endmodule

// File: rtl/biasVecGen.sv
module biasVecGen #(
  parameter int NUM_IN    = 4,
  parameter int SLICE_W   = 4,
  parameter int COMB_W    = 3,
  parameter int SEQ_LEN   = 8,
  parameter int NUM_SEEDS = 3,
  parameter logic [NUM_IN*SLICE_W-1:0] TAP_MASK  = 16'hB400,
  parameter logic [NUM_IN*SLICE_W-1:0] ZERO_SEED = 16'hACE1,
  localparam int LFSR_W = NUM_IN * SLICE_W,
  localparam int SEL_W  = (NUM_SEEDS > 1) ? $clog2(NUM_SEEDS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [NUM_SEEDS*LFSR_W-1:0] seedTable,
  input  logic [2*NUM_IN-1:0]         cubeCfg,
  output logic [NUM_IN-1:0]           vecOut,
  output logic                        vecValid,
  output logic                        initReq,
  output logic                        seqDone,
  output logic                        allDone
);

  biasvec_pkg::ctlStrobe_t strb;
  logic [SEL_W-1:0]        seedSel;

  biasvec_ctl #(.SEQ_LEN(SEQ_LEN), .NUM_SEEDS(NUM_SEEDS)) i_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .strb    (strb),
    .seedSel (seedSel),
    .initReq (initReq),
    .vecValid(vecValid),
    .seqDone (seqDone),
    .allDone (allDone)
  );

  biasvec_dp #(
    .NUM_IN(NUM_IN), .SLICE_W(SLICE_W), .COMB_W(COMB_W),
    .NUM_SEEDS(NUM_SEEDS), .TAP_MASK(TAP_MASK), .ZERO_SEED(ZERO_SEED)
  ) i_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .seedSel  (seedSel),
    .seedTable(seedTable),
    .cubeCfg  (cubeCfg),
    .vecBits  (vecOut)
  );

endmodule

// File: tb/test_biasVecGen.sv
module test_biasVecGen;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int D  = 4;
  localparam int M  = 3;
  localparam int L  = 8;
  localparam int S  = 3;
  localparam int W  = N * D;
  localparam logic [W-1:0] TAPS = 16'hB400;
  localparam logic [W-1:0] ZSUB = 16'hACE1;
  localparam int NENT = 4;
  // entry = {cube[7:0], seed2, seed1, seed0}
  localparam logic [2*N+S*W-1:0] TBL [NENT] = '{
    {8'b00_00_00_00, 16'h1234, 16'h8001, 16'hFFFF},
    {8'b01_01_01_01, 16'h0F0F, 16'h0000, 16'h5A5A},
    {8'b11_10_11_10, 16'hC3A5, 16'h7777, 16'h0001},
    {8'b10_01_00_11, 16'hBEEF, 16'h2468, 16'hDEAD}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [S*W-1:0] seedTable = '0;
  logic [2*N-1:0] cubeCfg = '0;
  logic [N-1:0] vecOut;
  logic vecValid, initReq, seqDone, allDone;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  biasVecGen i_biasVecGen (
    .clk(clk), .rst_n(rst_n), .start(start), .seedTable(seedTable),
    .cubeCfg(cubeCfg), .vecOut(vecOut), .vecValid(vecValid),
    .initReq(initReq), .seqDone(seqDone), .allDone(allDone)
  );

  function automatic logic [W-1:0] mStep(logic [W-1:0] s);
    return {s[W-2:0], ^(s & TAPS)};
  endfunction

  function automatic logic [N-1:0] mBias(logic [W-1:0] s, logic [2*N-1:0] c);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      logic [D-1:0] sl;
      sl = s[i*D +: D];
      case (c[2*i +: 2])
        2'b00:   r[i] = &sl[M-1:0];
        2'b01:   r[i] = |sl[M-1:0];
        default: r[i] = sl[0];
      endcase
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Runs one table entry; poke raises start mid-run (R10)
  task automatic runEntry(input int e, input bit poke);
    logic [W-1:0] st;
    cubeCfg   = TBL[e][2*N+S*W-1 -: 2*N];
    seedTable = TBL[e][S*W-1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int s = 0; s < S; s++) begin
      if (s > 0) @(negedge clk);
      chk(initReq && !vecValid, "R2 R9 initReq before seed", {vecValid, initReq}, 1);
      st = seedTable[s*W +: W];
      if (st == '0) st = ZSUB; // R5
      for (int k = 0; k < L; k++) begin
        @(negedge clk);
        chk(vecValid, "R2 vecValid", vecValid, 1);
        chk(vecOut == mBias(st, cubeCfg), "R4 R6 R7 R8 R9 vecOut", vecOut, mBias(st, cubeCfg));
        chk(seqDone == (k == L-1), "R3 seqDone", seqDone, (k == L-1));
        start = (poke && k == 2);
        st = mStep(st);
      end
    end
    @(negedge clk);
    chk(allDone && !vecValid && !initReq, "R10 allDone after last seed",
        {allDone, vecValid, initReq}, 3'b100);
    repeat (3) @(negedge clk);
    chk(allDone && !vecValid, "R10 allDone sticky", {allDone, vecValid}, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({vecValid, initReq, seqDone, allDone} == 4'b0, "R1 reset outputs",
        {vecValid, initReq, seqDone, allDone}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({vecValid, initReq, seqDone, allDone} == 4'b0, "R1 idle without start",
        {vecValid, initReq, seqDone, allDone}, 0);
    // table walk; entries after the first restart from DONE (R11)
    for (int e = 0; e < NENT; e++) begin
      runEntry(e, e == 2);
    end
    // R11: restart again from DONE, same table, seed 0 vectors first
    runEntry(0, 1'b0);
    // reset in mid-run returns to idle (R1)
    cubeCfg = 8'h55;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk({vecValid, initReq, seqDone, allDone} == 4'b0, "R1 reset mid-run",
        {vecValid, initReq, seqDone, allDone}, 0);
    rst_n = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule